// File: doc/BRIEF.md
# Latched BCD Seven-Segment Decoder

This block holds one binary-coded decimal digit in a register and turns it into the seven lines that drive the segments of a numeric display. The register loads on every rising clock edge while the load enable is high. It holds its contents while the enable is low, so the display keeps showing the last captured digit while the data bus carries other values.

Two controls act on the decoded word without any clock delay. A blanking control turns every segment off. A polarity control inverts all seven lines. Because of the polarity control, one design serves three kinds of display:

- Common-cathode LEDs use polarity low.
- Common-anode LEDs use polarity high.
- An LCD uses a square wave on the polarity input, the same wave that drives its backplane.

Input codes above nine show nothing.

Top module: `bcd_seg_driver`

## Requirements
- R1: While `load_en` is high, each rising clock edge copies `code_in` into the stored digit. From that edge on, `seg_out` shows the new digit.
- R2: While `load_en` is low, the stored digit and the displayed pattern stay unchanged, whatever `code_in` does.
- R3: A synchronous active-high `rst` clears the stored digit to zero. With `blank` and `invert` low, the display then shows digit 0.
- R4: `code_in` is weighted 8-4-2-1, with bit 3 the most significant. `seg_out[6]` is segment a and `seg_out[0]` is segment g, in the order a,b,c,d,e,f,g. With both controls low, digits 0 to 9 give the following patterns:

| Digit | Pattern |
|---|---|
| 0 | 1111110 |
| 1 | 0110000 |
| 2 | 1101101 |
| 3 | 1111001 |
| 4 | 0110011 |
| 5 | 1011011 |
| 6 | 1011111 |
| 7 | 1110000 |
| 8 | 1111111 |
| 9 | 1111011 |

- R5: Stored codes 10 to 15 give the all-off word 0000000 before polarity is applied.
- R6: While `blank` is high, the pre-polarity word is 0000000 for every stored code.
- R7: While `invert` is high, `seg_out` is the bitwise inverse of the word that R4, R5 and R6 give. Blanking is therefore inverted too, to 1111111.
- R8: `blank` and `invert` are combinational. A change on either shows on `seg_out` in the same cycle, without a clock edge, and does not change the stored digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the digit register samples on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the stored digit |
| code_in | input | 4 | BCD digit to capture |
| load_en | input | 1 | High: capture `code_in` on each edge; low: hold |
| blank | input | 1 | High: all segments off, before polarity |
| invert | input | 1 | High: invert all seven segment lines |
| seg_out | output | 7 | Segment lines; bit 6 is a, bit 0 is g |

## Verification
The bench builds the block with its default 4-bit code and 7-segment word. At that size every one of the sixteen codes can be stored and checked with both polarity values. Blanking is checked on all sixteen codes as well, with and without inversion. The hold test changes `code_in` over several clock edges while loading is off, and then flips `blank` and `invert` to show that the stored digit survives.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    localparam int CODE_W   = 4;
    localparam int SEG_W    = 7;
    localparam int MAX_DIGIT = 9;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    typedef struct packed {
        logic blank;
        logic invert;
    } drive_ctl_t;

    localparam seg_t SEG_DARK = '0;

    // Segment word ordered a (MSB) .. g (LSB), active high.
    function automatic seg_t digit_glyph(input code_t c);
        seg_t g;
        case (c)
            code_t'(0): g = 7'b1111110;
            code_t'(1): g = 7'b0110000;
            code_t'(2): g = 7'b1101101;
            code_t'(3): g = 7'b1111001;
            code_t'(4): g = 7'b0110011;
            code_t'(5): g = 7'b1011011;
            code_t'(6): g = 7'b1011111;
            code_t'(7): g = 7'b1110000;
            code_t'(8): g = 7'b1111111;
            code_t'(9): g = 7'b1111011;
            default:    g = SEG_DARK;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/seg7_digit_store.sv
module seg7_digit_store #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load_en)
            q <= d;
    end

    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        load_en |=> q == $past(d));                                 // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(q));                                   // R2

endmodule

// File: rtl/seg7_glyph_decode.sv
module seg7_glyph_decode
    import seg7_pkg::*;
(
    input  code_t digit,
    input  logic  blank,
    output seg_t  seg_raw
);

    logic in_range;

    always_comb begin
        in_range = (digit <= code_t'(MAX_DIGIT));
        if (blank || !in_range)
            seg_raw = SEG_DARK;
        else
            seg_raw = digit_glyph(digit);
    end

endmodule

// File: rtl/seg7_polarity.sv
module seg7_polarity #(
    parameter int WIDTH = 7
) (
    input  logic [WIDTH-1:0] din,
    input  logic             invert,
    output logic [WIDTH-1:0] dout
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[i] ^ invert;
    end

endmodule

// File: rtl/bcd_seg_driver.sv
module bcd_seg_driver
    import seg7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              load_en,
    input  logic              blank,
    input  logic              invert,
    output logic [SEG_W-1:0]  seg_out
);

    code_t      held_digit;
    seg_t       seg_raw;
    drive_ctl_t ctl;

    assign ctl.blank  = blank;
    assign ctl.invert = invert;

    seg7_digit_store #(.WIDTH(CODE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .d       (code_in),
        .q       (held_digit)
    );

    seg7_glyph_decode u_decode (
        .digit   (held_digit),
        .blank   (ctl.blank),
        .seg_raw (seg_raw)
    );

    seg7_polarity #(.WIDTH(SEG_W)) u_pol (
        .din    (seg_raw),
        .invert (ctl.invert),
        .dout   (seg_out)
    );

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        (blank && !invert) |-> seg_out == '0);                      // R6
    AST_BLANK_INVERTED: assert property (@(posedge clk) disable iff (rst)
        (blank && invert) |-> seg_out == '1);                       // R7
    AST_OVERRANGE_DARK: assert property (@(posedge clk) disable iff (rst)
        (!blank && !invert && held_digit > code_t'(MAX_DIGIT)) |-> seg_out == '0); // R5
    AST_EIGHT_FULL: assert property (@(posedge clk) disable iff (rst)
        (!blank && !invert && held_digit == code_t'(8)) |-> seg_out == '1); // R4

endmodule

// File: tb/bcd_seg_driver_test.sv
module bcd_seg_driver_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] code_in;
    logic       load_en;
    logic       blank;
    logic       invert;
    logic [6:0] seg_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bcd_seg_driver uut (
        .clk     (clk),
        .rst     (rst),
        .code_in (code_in),
        .load_en (load_en),
        .blank   (blank),
        .invert  (invert),
        .seg_out (seg_out)
    );

    // Expected pattern from segment membership rules (a..g, MSB = a).
    function automatic logic [6:0] expect_seg(input int d, input bit b, input bit inv);
        logic [6:0] s;
        if (b || d > 9) s = 7'b0;
        else begin
            s[6] = !(d == 1 || d == 4);
            s[5] = !(d == 5 || d == 6);
            s[4] = (d != 2);
            s[3] = !(d == 1 || d == 4 || d == 7);
            s[2] = (d == 0 || d == 2 || d == 6 || d == 8);
            s[1] = !(d == 1 || d == 2 || d == 3 || d == 7);
            s[0] = !(d == 0 || d == 1 || d == 7);
        end
        return inv ? ~s : s;
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        n_checks++;
        if (seg_out !== exp) begin
            n_fail++;
            $display("FAIL %s: seg_out=%b expected=%b", req, seg_out, exp);
        end
    endtask

    task automatic load_digit(input int d);
        @(negedge clk);
        code_in = 4'(d);
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic set_ctl(input bit b, input bit inv);
        blank  = b;
        invert = inv;
        #1;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst = 1'b1; code_in = 4'd7; load_en = 1'b0; blank = 1'b0; invert = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check("R3 reset shows digit 0", expect_seg(0, 0, 0));

        // R4 R5 R7 R8: every code, both polarities, toggled without a clock edge
        for (int d = 0; d < 16; d++) begin
            load_digit(d);
            set_ctl(0, 0);
            check(d > 9 ? "R5 overrange dark" : "R4 R1 decode", expect_seg(d, 0, 0));
            set_ctl(0, 1);
            check("R7 R8 inverted", expect_seg(d, 0, 1));
            set_ctl(0, 0);
        end

        // R2: hold while code_in wanders with load_en low
        load_digit(3);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            code_in = 4'(k * 3 + 1);
            @(negedge clk);
            #1 check("R2 hold", expect_seg(3, 0, 0));
        end
        set_ctl(1, 0);
        check("R6 blank over held", expect_seg(3, 1, 0));
        set_ctl(0, 0);
        check("R8 R2 digit survives blank", expect_seg(3, 0, 0));

        // R6 R7: blanking on every stored code, both polarities
        for (int d = 0; d < 16; d++) begin
            load_digit(d);
            set_ctl(1, 0);
            check("R6 blank", 7'b0000000);
            set_ctl(1, 1);
            check("R7 blank inverted", 7'b1111111);
            set_ctl(0, 0);
            check("R8 unblank", expect_seg(d, 0, 0));
        end

        // R3: reset mid-run clears digit
        load_digit(8);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R3 reset clears", expect_seg(0, 0, 0));

        finish_run();
    end

endmodule